// File: doc/BRIEF.md
# Floppy Controller Configuration Command Handler

This block sits behind the byte-wide command port of a floppy disk controller. It watches command writes for the configuration opcode and collects the three bytes that follow. When the last byte arrives it loads the operating parameters: FIFO threshold, FIFO disable, drive-polling disable, implied-seek enable and the write-precompensation start track. The command has no result phase, so the block drops straight back to idle after the last byte.

A hardware reset loads the power-up defaults. A software reset always clears the polling-disable and implied-seek bits. The threshold, FIFO disable and precompensation track go back to their defaults only when the lock input is low; when it is high, they keep their values. The effective implied-seek signal combines the stored enable with an external mode-command bit.

After every reset a timed window opens. It lasts `CYC_PER_MS * WINDOW_MS` clock cycles. If a configuration command that disables polling completes inside the window, the post-reset polling interrupt is cancelled. Otherwise the interrupt is raised when the window runs out.

Top module: `fdc_cfg_cmd`

## Requirements
- R1: A hardware reset (`rst` high at a clock edge) gives the following values on the next cycle: `cfg_thresh`=0, `cfg_fifo_dis`=1, `cfg_poll_dis`=0, `cfg_seek_en`=0, `cfg_pretrk`=0, `busy`=0 and `poll_irq`=0. The value of `lock_in` does not matter.
- R2: A command is four strobed bytes:
  - the opcode 0x13;
  - one byte whose value is ignored;
  - a flags byte, where bit 6 goes to `cfg_seek_en`, bit 5 to `cfg_fifo_dis`, bit 4 to `cfg_poll_dis` and bits 3:0 to `cfg_thresh` (bit 7 is ignored);
  - a track byte that goes whole to `cfg_pretrk`.

  The new values appear in the cycle after the fourth strobe.
- R3: In idle, a strobed byte other than 0x13 leaves `busy` low and leaves every configuration output unchanged.
- R4: `busy` goes high in the cycle after the opcode strobe and stays high until the fourth strobe. It is low in the cycle after the fourth strobe, and the next strobe is decoded as a new opcode.
- R5: On a software reset (`sw_rst` high at an edge), if `lock_in`=0 the threshold becomes 0, FIFO disable becomes 1 and the track becomes 0. If `lock_in`=1, these three fields keep their values.
- R6: A software reset always clears `cfg_poll_dis` and `cfg_seek_en`. It also abandons any partly received command, so `busy` is low on the next cycle.
- R7: In each cycle, `seek_eff` equals the OR of `cfg_seek_en` and `mode_seek_in` as they were in the previous cycle.
- R8: After a hardware or software reset edge, if no suppressing command arrives, `poll_irq` rises on the WIN-th clock edge after the reset edge, where WIN = `CYC_PER_MS*WINDOW_MS`. It then stays high until the next reset.
- R9: A command with flags bit 4 = 1 whose fourth strobe falls on edge 1 to WIN after a reset keeps `poll_irq` low for that whole reset period. A command with bit 4 = 0 does not suppress the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hardware reset, synchronous, active high |
| sw_rst | input | 1 | Software reset pulse, synchronous, active high |
| lock_in | input | 1 | Lock flag: keep threshold, FIFO disable and track across a software reset |
| mode_seek_in | input | 1 | Implied-seek enable from the mode command |
| wr_stb | input | 1 | One-cycle command byte write strobe |
| wr_data | input | 8 | Command byte |
| busy | output | 1 | Configuration command partly received |
| cfg_thresh | output | 4 | FIFO threshold |
| cfg_fifo_dis | output | 1 | FIFO disabled |
| cfg_poll_dis | output | 1 | Drive polling disabled |
| cfg_seek_en | output | 1 | Stored implied-seek enable |
| cfg_pretrk | output | 8 | Precompensation start track |
| seek_eff | output | 1 | Effective implied-seek enable |
| poll_irq | output | 1 | Post-reset polling interrupt |

## Verification
Each failure mode shows at the ports within a bounded time:
- **Wrong byte counter.** A misplaced byte counter shows up one cycle after the misplaced strobe. Either `busy` stays high or drops early, or the configuration fields take on bits from the wrong byte.
- **Wrong lock handling.** A fault in the lock logic shows up on the cycle right after a software reset, as a field that was kept or restored when it should not have been.
- **Wrong window counter.** A window counter that is off by one moves the edge where `poll_irq` rises by one cycle. It also changes the outcome of a suppressing command whose last byte lands exactly on the final window edge. The bench probes both sides of that boundary.

// File: rtl/fdc_cfg_pkg.sv
package fdc_cfg_pkg;
  localparam logic [7:0] CFG_OPCODE = 8'h13;
  localparam int THR_W    = 4;
  localparam int TRK_W    = 8;
  localparam int FLG_W    = 7;
  localparam int SEEK_BIT = 6;
  localparam int FIFO_BIT = 5;
  localparam int POLL_BIT = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RSVD,
    ST_FLAGS,
    ST_TRACK
  } cmd_state_t;

  typedef struct packed {
    logic             seek_en;
    logic             fifo_dis;
    logic             poll_dis;
    logic [THR_W-1:0] thresh;
    logic [TRK_W-1:0] pretrk;
  } cfg_t;

  localparam cfg_t CFG_DEFAULT = '{
    seek_en:  1'b0,
    fifo_dis: 1'b1,
    poll_dis: 1'b0,
    thresh:   '0,
    pretrk:   '0
  };
endpackage

// File: rtl/fdc_cfg_parser.sv
module fdc_cfg_parser
  import fdc_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_rst,
  input  logic             wr_stb,
  input  logic [7:0]       wr_data,
  output logic             busy,
  output logic             fire,
  output logic [FLG_W-1:0] flags_byte,
  output logic [TRK_W-1:0] track_byte
);
  cmd_state_t       st, st_nx;
  logic [FLG_W-1:0] flags_q;

  always_comb begin
    st_nx = st;
    if (wr_stb) begin
      case (st)
        ST_IDLE:  if (wr_data == CFG_OPCODE) st_nx = ST_RSVD;
        ST_RSVD:  st_nx = ST_FLAGS;
        ST_FLAGS: st_nx = ST_TRACK;
        ST_TRACK: st_nx = ST_IDLE;
        default:  st_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || sw_rst) begin
      st      <= ST_IDLE;
      busy    <= 1'b0;
      flags_q <= '0;
    end else begin
      st   <= st_nx;
      busy <= (st_nx != ST_IDLE);
      if (wr_stb && st == ST_FLAGS) flags_q <= wr_data[FLG_W-1:0];
    end
  end

  assign fire       = (st == ST_TRACK) && wr_stb && !sw_rst;
  assign flags_byte = flags_q;
  assign track_byte = wr_data[TRK_W-1:0];

  assert_bad_op_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && wr_stb && wr_data != CFG_OPCODE && !sw_rst) |=> (st == ST_IDLE && !busy));
  assert_busy_after_op_R4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && wr_stb && wr_data == CFG_OPCODE && !sw_rst) |=> busy);
  assert_no_result_R4: assert property (@(posedge clk) disable iff (rst)
    fire |=> (!busy && st == ST_IDLE));
  assert_abort_R6: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> (!busy && st == ST_IDLE));
endmodule

// File: rtl/fdc_cfg_regs.sv
module fdc_cfg_regs
  import fdc_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_rst,
  input  logic             lock_in,
  input  logic             mode_seek_in,
  input  logic             fire,
  input  logic [FLG_W-1:0] flags_byte,
  input  logic [TRK_W-1:0] track_byte,
  output cfg_t             cfg,
  output logic             seek_eff
);
  cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= CFG_DEFAULT;
    end else if (sw_rst) begin
      cfg_q.poll_dis <= 1'b0;
      cfg_q.seek_en  <= 1'b0;
      if (!lock_in) begin
        cfg_q.thresh   <= CFG_DEFAULT.thresh;
        cfg_q.fifo_dis <= CFG_DEFAULT.fifo_dis;
        cfg_q.pretrk   <= CFG_DEFAULT.pretrk;
      end
    end else if (fire) begin
      cfg_q.seek_en  <= flags_byte[SEEK_BIT];
      cfg_q.fifo_dis <= flags_byte[FIFO_BIT];
      cfg_q.poll_dis <= flags_byte[POLL_BIT];
      cfg_q.thresh   <= flags_byte[THR_W-1:0];
      cfg_q.pretrk   <= track_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) seek_eff <= 1'b0;
    else     seek_eff <= cfg_q.seek_en | mode_seek_in;
  end

  assign cfg = cfg_q;

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    (fire && !sw_rst) |=> (cfg_q.thresh == $past(flags_byte[THR_W-1:0]) && cfg_q.pretrk == $past(track_byte)));
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!fire && !sw_rst) |=> $stable(cfg_q));
  assert_lock_keep_R5: assert property (@(posedge clk) disable iff (rst)
    (sw_rst && lock_in) |=> ($stable(cfg_q.thresh) && $stable(cfg_q.fifo_dis) && $stable(cfg_q.pretrk)));
  assert_unlock_default_R5: assert property (@(posedge clk) disable iff (rst)
    (sw_rst && !lock_in) |=> (cfg_q.thresh == '0 && cfg_q.fifo_dis && cfg_q.pretrk == '0));
  assert_swrst_clear_R6: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> (!cfg_q.poll_dis && !cfg_q.seek_en));
  assert_mode_seek_R7: assert property (@(posedge clk) disable iff (rst)
    mode_seek_in |=> seek_eff);
endmodule

// File: rtl/fdc_poll_window.sv
module fdc_poll_window #(
  parameter int unsigned CYC_PER_MS = 100000,
  parameter int unsigned WINDOW_MS  = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic sw_rst,
  input  logic fire,
  input  logic fire_poll_dis,
  output logic poll_irq
);
  localparam int unsigned WIN  = CYC_PER_MS * WINDOW_MS;
  localparam int          CW   = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [CW-1:0] LOAD = CW'(WIN - 1);

  logic [CW-1:0] cnt;
  logic          armed;

  always_ff @(posedge clk) begin
    if (rst || sw_rst) begin
      cnt      <= LOAD;
      armed    <= 1'b1;
      poll_irq <= 1'b0;
    end else if (armed) begin
      if (fire && fire_poll_dis) begin
        armed <= 1'b0;
      end else if (cnt == '0) begin
        armed    <= 1'b0;
        poll_irq <= 1'b1;
      end else begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (poll_irq && !sw_rst) |=> poll_irq);
  assert_irq_on_expiry_R8: assert property (@(posedge clk) disable iff (rst || sw_rst)
    $rose(poll_irq) |-> $past(armed && cnt == '0));
  assert_suppress_R9: assert property (@(posedge clk) disable iff (rst)
    (armed && fire && fire_poll_dis && !sw_rst) |=> (!armed && !poll_irq));
endmodule

// File: rtl/fdc_cfg_cmd.sv
module fdc_cfg_cmd
  import fdc_cfg_pkg::*;
#(
  parameter int unsigned CYC_PER_MS = 100000,
  parameter int unsigned WINDOW_MS  = 500
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_rst,
  input  logic             lock_in,
  input  logic             mode_seek_in,
  input  logic             wr_stb,
  input  logic [7:0]       wr_data,
  output logic             busy,
  output logic [THR_W-1:0] cfg_thresh,
  output logic             cfg_fifo_dis,
  output logic             cfg_poll_dis,
  output logic             cfg_seek_en,
  output logic [TRK_W-1:0] cfg_pretrk,
  output logic             seek_eff,
  output logic             poll_irq
);
  logic             fire;
  logic [FLG_W-1:0] flags_byte;
  logic [TRK_W-1:0] track_byte;
  cfg_t             cfg;

  fdc_cfg_parser u_parser (
    .clk(clk), .rst(rst), .sw_rst(sw_rst),
    .wr_stb(wr_stb), .wr_data(wr_data),
    .busy(busy), .fire(fire),
    .flags_byte(flags_byte), .track_byte(track_byte)
  );

  fdc_cfg_regs u_regs (
    .clk(clk), .rst(rst), .sw_rst(sw_rst),
    .lock_in(lock_in), .mode_seek_in(mode_seek_in),
    .fire(fire), .flags_byte(flags_byte), .track_byte(track_byte),
    .cfg(cfg), .seek_eff(seek_eff)
  );

  fdc_poll_window #(.CYC_PER_MS(CYC_PER_MS), .WINDOW_MS(WINDOW_MS)) u_window (
    .clk(clk), .rst(rst), .sw_rst(sw_rst),
    .fire(fire), .fire_poll_dis(flags_byte[POLL_BIT]),
    .poll_irq(poll_irq)
  );

  assign cfg_thresh   = cfg.thresh;
  assign cfg_fifo_dis = cfg.fifo_dis;
  assign cfg_poll_dis = cfg.poll_dis;
  assign cfg_seek_en  = cfg.seek_en;
  assign cfg_pretrk   = cfg.pretrk;

  assert_reset_defaults_R1: assert property (@(posedge clk)
    rst |=> (cfg_fifo_dis && !cfg_poll_dis && !cfg_seek_en && cfg_thresh == '0 &&
             cfg_pretrk == '0 && !busy && !poll_irq));
endmodule

// File: tb/test_fdc_cfg_cmd.sv
module test_fdc_cfg_cmd;
  localparam int unsigned CPM = 2;
  localparam int unsigned WMS = 500;
  localparam int WIN = CPM * WMS;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sw_rst = 1'b0;
  logic       lock_in = 1'b0;
  logic       mode_seek_in = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       busy, cfg_fifo_dis, cfg_poll_dis, cfg_seek_en, seek_eff, poll_irq;
  logic [3:0] cfg_thresh;
  logic [7:0] cfg_pretrk;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fdc_cfg_cmd #(.CYC_PER_MS(CPM), .WINDOW_MS(WMS)) i_fdc_cfg_cmd (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .lock_in(lock_in),
    .mode_seek_in(mode_seek_in), .wr_stb(wr_stb), .wr_data(wr_data),
    .busy(busy), .cfg_thresh(cfg_thresh), .cfg_fifo_dis(cfg_fifo_dis),
    .cfg_poll_dis(cfg_poll_dis), .cfg_seek_en(cfg_seek_en),
    .cfg_pretrk(cfg_pretrk), .seek_eff(seek_eff), .poll_irq(poll_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    wr_stb = 1'b1; wr_data = b;
    @(negedge clk);
    wr_stb = 1'b0; wr_data = 8'h00;
  endtask

  task automatic send_cmd(input logic [7:0] flags, input logic [7:0] trk);
    send(8'h13); send(8'hA5); send(flags); send(trk);
  endtask

  task automatic hw_reset();
    rst = 1'b1; @(negedge clk); rst = 1'b0;
  endtask

  task automatic soft_reset();
    sw_rst = 1'b1; @(negedge clk); sw_rst = 1'b0;
  endtask

  task automatic chk_fields(input string req, input logic [7:0] f, input logic [7:0] t);
    chk(req, cfg_thresh, f & 8'h0F);
    chk(req, cfg_fifo_dis, (f >> 5) & 1);
    chk(req, cfg_poll_dis, (f >> 4) & 1);
    chk(req, cfg_seek_en, (f >> 6) & 1);
    chk(req, cfg_pretrk, t);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] fl, tk;
    idle(2);
    // R1: reset defaults, lock high during reset does not matter
    lock_in = 1'b1;
    hw_reset();
    lock_in = 1'b0;
    chk("R1 thresh", cfg_thresh, 0);
    chk("R1 fifo_dis", cfg_fifo_dis, 1);
    chk("R1 poll_dis", cfg_poll_dis, 0);
    chk("R1 seek_en", cfg_seek_en, 0);
    chk("R1 pretrk", cfg_pretrk, 0);
    chk("R1 busy", busy, 0);
    chk("R1 irq", poll_irq, 0);

    // R3: every non-opcode byte ignored in idle
    for (int i = 0; i < 256; i++) begin
      if (i != 8'h13) begin
        send(i[7:0]);
        chk("R3 busy", busy, 0);
      end
    end
    chk_fields("R3 fields unchanged", 8'h20, 8'h00);

    // R2/R4: sweep flags byte, track derived arithmetically
    for (int i = 0; i < 256; i++) begin
      fl = i[7:0];
      tk = 8'((i * 37 + 11) % 256);
      send(8'h13);
      chk("R4 busy after opcode", busy, 1);
      send(~fl);
      chk("R4 busy after byte2", busy, 1);
      send(fl);
      chk("R4 busy after byte3", busy, 1);
      send(tk);
      chk("R4 busy after byte4", busy, 0);
      chk_fields("R2 fields", fl, tk);
    end

    // R4: back-to-back commands, no result phase
    send_cmd(8'h3C, 8'h77);
    send_cmd(8'h41, 8'h09);
    chk_fields("R4 back-to-back", 8'h41, 8'h09);

    // R5/R6: software reset with lock clear / set
    for (int lk = 0; lk < 2; lk++) begin
      for (int p = 0; p < 4; p++) begin
        fl = 8'((p * 29 + 8'h50) % 128) | 8'h50;
        tk = 8'(p * 61 + 3);
        send_cmd(fl, tk);
        lock_in = lk[0];
        soft_reset();
        lock_in = 1'b0;
        if (lk == 0) chk_fields("R5 unlocked defaults", 8'h20, 8'h00);
        else         chk_fields("R5 locked keep", fl & 8'h2F, tk);
        chk("R6 poll cleared", cfg_poll_dis, 0);
        chk("R6 seek cleared", cfg_seek_en, 0);
      end
    end

    // R6: abort partial command
    send(8'h13); send(8'h00);
    soft_reset();
    chk("R6 abort busy", busy, 0);
    send_cmd(8'h2F, 8'hEE);
    chk_fields("R6 after abort", 8'h2F, 8'hEE);

    // R7: effective implied seek
    for (int m = 0; m < 4; m++) begin
      send_cmd(m[0] ? 8'h40 : 8'h00, 8'h01);
      mode_seek_in = m[1];
      idle(2);
      chk("R7 seek_eff", seek_eff, m[0] | m[1]);
    end
    mode_seek_in = 1'b0;

    // R8: window expires without command
    hw_reset();
    idle(WIN - 1);
    chk("R8 irq before expiry", poll_irq, 0);
    idle(1);
    chk("R8 irq at expiry", poll_irq, 1);
    idle(10);
    chk("R8 irq sticky", poll_irq, 1);

    // R9: suppressing command ends exactly on last window edge
    hw_reset();
    idle(WIN - 4);
    send_cmd(8'h10, 8'h00);
    idle(20);
    chk("R9 suppressed at boundary", poll_irq, 0);

    // R9: one edge too late
    hw_reset();
    idle(WIN - 3);
    send_cmd(8'h10, 8'h00);
    chk("R9 late command", poll_irq, 1);

    // R9: command without polling disable does not suppress
    hw_reset();
    idle(5);
    send_cmd(8'h00, 8'h00);
    idle(WIN - 10);
    chk("R9 no-suppress before", poll_irq, 0);
    idle(1);
    chk("R9 no-suppress expiry", poll_irq, 1);

    // R8: software reset clears irq and reopens the window
    soft_reset();
    chk("R8 swrst clears irq", poll_irq, 0);
    idle(WIN - 4);
    send_cmd(8'h10, 8'h00);
    idle(20);
    chk("R9 suppressed after swrst", poll_irq, 0);
    soft_reset();
    idle(WIN - 1);
    chk("R8 swrst window before", poll_irq, 0);
    idle(1);
    chk("R8 swrst window expiry", poll_irq, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule